// File: doc/BRIEF.md
# Direct-Page Bit Clear Unit

This block carries out one instruction: clearing a single bit of a byte that sits in the first 256 locations of a byte-wide memory. The instruction arrives as two bytes on one byte-wide input, each qualified by a valid strobe. The first byte is an opcode, and that opcode alone names the bit to be cleared. The second byte is the memory address. The unit then reads the addressed byte through a synchronous memory port. It writes the byte back with the chosen bit forced low and every other bit kept. It pulses a completion strobe in the cycle of that write.

The eight accepted opcodes are the odd values from 0x11 to 0x1F. Any other opcode byte presented while the unit is idle is dropped. In that case an illegal-opcode pulse is raised and the memory is not touched. The unit has no connection to any condition-code or flag register, so the flags stay as they are.

When the address byte follows the opcode directly, an instruction takes four clock cycles: opcode accept, address accept, read, and write. A new opcode is taken only while the busy output is low.

Top module: `bit_clear_unit`

## Requirements
- R1: An opcode byte of value 0x11 + 2·n (n = 0..7) clears bit n of the addressed byte. After the write, bit n is 0 and the other seven bits are unchanged.
- R2: The first valid byte after an accepted opcode is taken as the address. memAddr equals that byte in both the read cycle and the write cycle.
- R3: memRe is high for exactly one cycle per instruction. That cycle is the one after the address byte is accepted, and memWe is low in it.
- R4: memWe is high for exactly one cycle, the cycle after the read. In that cycle memWdata equals memRdata with bit n cleared.
- R5: If the address byte is presented in the cycle right after the opcode, done is high in the fourth cycle, counting the opcode cycle as the first.
- R6: done is a single-cycle pulse, and it is high only in the cycle where memWe is high.
- R7: busy is high from the cycle after opcode accept through the write cycle. Valid bytes that arrive during the read or write cycle are ignored.
- R8: An opcode outside the eight legal values, presented while idle, raises illegal for exactly one cycle, in the following cycle. It causes no memory read, no write and no done, and busy stays low.
- R9: While the unit waits for the address byte, cycles with inValid low leave it waiting with busy high and no memory access.
- R10: Synchronous active-high reset returns the unit to idle. After reset, busy, done, illegal, memRe and memWe are low, and an interrupted instruction performs no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | inByte carries an opcode or address byte this cycle |
| inByte | input | 8 | Opcode or direct address byte |
| busy | output | 1 | An instruction is in progress; opcodes are not taken |
| done | output | 1 | One-cycle completion pulse, in the write cycle |
| illegal | output | 1 | One-cycle pulse after an unrecognised opcode |
| memAddr | output | 8 | Memory address for read and write |
| memRe | output | 1 | Memory read strobe; data is returned on memRdata the next cycle |
| memWe | output | 1 | Memory write strobe |
| memWdata | output | 8 | Byte to be written |
| memRdata | input | 8 | Read data, valid in the cycle after memRe |

## Verification
The bench runs each of the eight opcodes against a byte of all ones. A wrong bit-index decode would then show up as the wrong bit going low, or as two bits going low. Illegal opcodes that differ from legal ones only in the upper nibble or in the low bit are checked. A decoder that looked only at part of the byte would then write memory or fail to raise illegal. The bench also stalls the address byte for several cycles and sends stray valid bytes during the read and write cycles. A unit that did not hold in the address state, or that re-decoded input while busy, would then access memory early or start a second instruction. A reset asserted in the read cycle must leave no write behind; a design that let a write slip through would corrupt memory.

// File: rtl/bclr_pkg.sv
package bclr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADDR  = 2'd1,
    ST_READ  = 2'd2,
    ST_WRITE = 2'd3
  } seqState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic ldBit;
    logic ldAddr;
    logic rdEn;
    logic wrEn;
  } dpCtrl_t;

endpackage

// File: rtl/bclr_ctrl.sv
module bclr_ctrl
  import bclr_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    inValid,
  input  logic    opLegal,
  output dpCtrl_t ctl,
  output logic    busy,
  output logic    done,
  output logic    illegal
);

  seqState_t stateQ, stateD;
  logic      illegalQ;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:  if (inValid && opLegal) stateD = ST_ADDR;
      ST_ADDR:  if (inValid)            stateD = ST_READ;
      ST_READ:                          stateD = ST_WRITE;
      ST_WRITE:                         stateD = ST_IDLE;
      default:                          stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ   <= ST_IDLE;
      illegalQ <= 1'b0;
    end else begin
      stateQ   <= stateD;
      illegalQ <= (stateQ == ST_IDLE) && inValid && !opLegal;
    end
  end

  always_comb begin
    ctl.ldBit  = (stateQ == ST_IDLE) && inValid && opLegal;
    ctl.ldAddr = (stateQ == ST_ADDR) && inValid;
    ctl.rdEn   = (stateQ == ST_READ);
    ctl.wrEn   = (stateQ == ST_WRITE);
  end

  assign busy    = (stateQ != ST_IDLE);
  assign done    = (stateQ == ST_WRITE);
  assign illegal = illegalQ;

endmodule

// File: rtl/bclr_dpath.sv
module bclr_dpath
  import bclr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  dpCtrl_t           ctl,
  input  logic [DATA_W-1:0] inByte,
  output logic              opLegal,
  output logic [DATA_W-1:0] memAddr,
  output logic              memRe,
  output logic              memWe,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata
);

  localparam int IDX_W = $clog2(DATA_W);

  logic [IDX_W-1:0]  bitIdxQ;
  logic [DATA_W-1:0] addrQ;

  // legal opcodes: upper part equals 1, lowest bit set; index in bits above bit 0
  assign opLegal = (inByte[DATA_W-1:4] == (DATA_W-4)'(1)) && inByte[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      bitIdxQ <= '0;
      addrQ   <= '0;
    end else begin
      if (ctl.ldBit)  bitIdxQ <= inByte[IDX_W:1];
      if (ctl.ldAddr) addrQ   <= inByte;
    end
  end

  // per-bit clear: the selected lane is forced low, the rest pass through
  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    assign memWdata[i] = memRdata[i] & (bitIdxQ != IDX_W'(i));
  end

  assign memAddr = addrQ;
  assign memRe   = ctl.rdEn;
  assign memWe   = ctl.wrEn;

endmodule

// File: rtl/bit_clear_unit.sv
module bit_clear_unit
  import bclr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inByte,
  output logic              busy,
  output logic              done,
  output logic              illegal,
  output logic [DATA_W-1:0] memAddr,
  output logic              memRe,
  output logic              memWe,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata
);

  dpCtrl_t ctl;
  logic    opLegal;

  bclr_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .opLegal (opLegal),
    .ctl     (ctl),
    .busy    (busy),
    .done    (done),
    .illegal (illegal)
  );

  bclr_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .inByte   (inByte),
    .opLegal  (opLegal),
    .memAddr  (memAddr),
    .memRe    (memRe),
    .memWe    (memWe),
    .memWdata (memWdata),
    .memRdata (memRdata)
  );

endmodule

// File: rtl/bit_clear_unit_chk.sv
module bit_clear_unit_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              illegal,
  input logic [DATA_W-1:0] memAddr,
  input logic              memRe,
  input logic              memWe,
  input logic [DATA_W-1:0] memWdata,
  input logic [DATA_W-1:0] memRdata
);

  // R3
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (rst)
    memRe |=> memWe && !memRe && (memAddr == $past(memAddr)));

  // R4
  wr_after_rd_chk: assert property (@(posedge clk) disable iff (rst)
    memWe |-> $past(memRe));

  // R4
  wr_one_bit_chk: assert property (@(posedge clk) disable iff (rst)
    memWe |-> (((memWdata & ~memRdata) == '0) && ($countones(memWdata ^ memRdata) <= 1)));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!memRe && !memWe && !done));

  // R7
  busy_cover_chk: assert property (@(posedge clk) disable iff (rst)
    (memRe || memWe) |-> busy);

  // R10
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!busy && !memRe && !memWe && !illegal && !done));

endmodule

bind bit_clear_unit bit_clear_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .done     (done),
  .illegal  (illegal),
  .memAddr  (memAddr),
  .memRe    (memRe),
  .memWe    (memWe),
  .memWdata (memWdata),
  .memRdata (memRdata)
);

// File: tb/bit_clear_unit_bench.sv
`timescale 1ns/1ps
module bit_clear_unit_bench;

  logic       clk = 1'b0;
  logic       rst;
  logic       inValid;
  logic [7:0] inByte;
  logic       busy, done, illegal, memRe, memWe;
  logic [7:0] memAddr, memWdata;
  logic [7:0] memRdata = 8'h00;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  bit started = 1'b0;

  always #2.5 clk = ~clk;

  bit_clear_unit u_bit_clear_unit (
    .clk(clk), .rst(rst), .inValid(inValid), .inByte(inByte),
    .busy(busy), .done(done), .illegal(illegal),
    .memAddr(memAddr), .memRe(memRe), .memWe(memWe),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  // bench memory, synchronous read
  logic [7:0] mem    [256];
  logic [7:0] refMem [256];

  always @(posedge clk) begin
    if (memRe) memRdata <= mem[memAddr];
    if (memWe) mem[memAddr] <= memWdata;
  end

  // behavioural reference: phase 0 idle, 1 wait address, 2 read, 3 write
  int         mPhase = 0;
  bit         mIll = 1'b0;
  int         mBit = 0;
  logic [7:0] mAddr = 8'h00;

  function automatic bit isLegal(input logic [7:0] b);
    return b inside {8'h11, 8'h13, 8'h15, 8'h17, 8'h19, 8'h1B, 8'h1D, 8'h1F};
  endfunction

  always @(posedge clk) begin
    started = 1'b1;
    if (rst) begin
      mPhase = 0;
      mIll   = 1'b0;
    end else begin
      mIll = 1'b0;
      case (mPhase)
        0: if (inValid) begin
             if (isLegal(inByte)) begin
               mBit   = (int'(inByte) - 17) / 2;
               mPhase = 1;
             end else mIll = 1'b1;
           end
        1: if (inValid) begin
             mAddr  = inByte;
             mPhase = 2;
           end
        2: mPhase = 3;
        default: begin
          refMem[mAddr] = refMem[mAddr] & ~(8'd1 << mBit);
          mPhase = 0;
        end
      endcase
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference, away from the rising edge
  always @(negedge clk) begin
    if (started && !finished) begin
      check(busy    === (mPhase != 0), "R7 busy",     busy,    mPhase != 0);
      check(memRe   === (mPhase == 2), "R3 memRe",    memRe,   mPhase == 2);
      check(memWe   === (mPhase == 3), "R4 memWe",    memWe,   mPhase == 3);
      check(done    === (mPhase == 3), "R6 done",     done,    mPhase == 3);
      check(illegal === mIll,          "R8 illegal",  illegal, mIll);
      if (mPhase >= 2)
        check(memAddr === mAddr, "R2 memAddr", memAddr, mAddr);
      if (mPhase == 3)
        check(memWdata === (refMem[mAddr] & ~(8'd1 << mBit)), "R4 memWdata",
              memWdata, refMem[mAddr] & ~(8'd1 << mBit));
    end
  end

  task automatic drive(input bit v, input logic [7:0] b);
    @(negedge clk);
    inValid = v;
    inByte  = b;
  endtask

  task automatic instr(input logic [7:0] op, input logic [7:0] addr);
    drive(1'b1, op);
    drive(1'b1, addr);
    drive(1'b0, 8'h00);
    drive(1'b0, 8'h00);
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
    end
  end

  initial begin
    rst = 1'b1;
    inValid = 1'b0;
    inByte = 8'h00;
    for (int i = 0; i < 256; i++) begin
      mem[i]    = 8'(i * 53) ^ 8'hA7;
      refMem[i] = 8'(i * 53) ^ 8'hA7;
    end
    for (int i = 0; i < 8; i++) begin
      mem[8'h10 + i]    = 8'hFF;
      refMem[8'h10 + i] = 8'hFF;
    end
    repeat (3) @(negedge clk);
    // R10 reset state
    check(!busy && !done && !illegal && !memRe && !memWe, "R10 reset outputs",
          {busy, done, illegal, memRe, memWe}, 0);
    rst = 1'b0;

    // R1 each opcode against an all-ones byte
    for (int n = 0; n < 8; n++) instr(8'(8'h11 + 2 * n), 8'(8'h10 + n));
    drive(1'b0, 8'h00);
    for (int n = 0; n < 8; n++)
      check(mem[8'h10 + n] === ~(8'd1 << n), "R1 single bit cleared",
            mem[8'h10 + n], ~(8'd1 << n));

    // R2 edge addresses
    instr(8'h1B, 8'h00);
    instr(8'h11, 8'hFF);

    // R8 near-miss illegal opcodes, then a legal one right after
    drive(1'b1, 8'h10);
    drive(1'b1, 8'h21);
    drive(1'b1, 8'h93);
    drive(1'b1, 8'h00);
    drive(1'b0, 8'h00);
    instr(8'h17, 8'h40);

    // R5 latency with operand back-to-back
    drive(1'b1, 8'h1D);
    check(!done, "R5 done early", done, 0);
    drive(1'b1, 8'h41);
    check(!done, "R5 done early", done, 0);
    drive(1'b0, 8'h00);
    check(!done, "R5 done early", done, 0);
    drive(1'b0, 8'h00);
    check(done === 1'b1, "R5 done in fourth cycle", done, 1);

    // R9 stalled address byte
    drive(1'b1, 8'h15);
    repeat (3) begin
      drive(1'b0, 8'h00);
      check(busy && !memRe && !memWe, "R9 waiting", {busy, memRe, memWe}, 3'b100);
    end
    drive(1'b1, 8'h42);
    drive(1'b0, 8'h00);
    drive(1'b0, 8'h00);

    // R7 stray bytes during read and write are ignored
    drive(1'b1, 8'h1F);
    drive(1'b1, 8'h43);
    drive(1'b1, 8'h13);
    drive(1'b1, 8'h15);
    drive(1'b0, 8'h00);
    check(!busy, "R7 stray byte ignored", busy, 0);

    // R10 reset during read: no write
    drive(1'b1, 8'h11);
    drive(1'b1, 8'h44);
    @(negedge clk);
    inValid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(!memWe && !busy, "R10 interrupted", {memWe, busy}, 0);
    repeat (2) drive(1'b0, 8'h00);
    check(mem[8'h44] === refMem[8'h44], "R10 no write after reset", mem[8'h44], refMem[8'h44]);

    // R1 full memory comparison
    for (int i = 0; i < 256; i++)
      check(mem[i] === refMem[i], "R1 memory image", mem[i], refMem[i]);

    finish_run();
  end

endmodule